// File: doc/BRIEF.md
# Accumulator ALU with BCD Addition

This block is the purely combinational arithmetic and logic stage of an 8-bit accumulator machine. It takes four things: the accumulator, one operand byte, the carry/link flag and the present overflow flag. It also takes the instruction byte being executed. From these it forms the next accumulator value, the next carry/link and the next overflow.

The surrounding machine owns the registers and memory. It feeds either a memory byte or its extension register as the operand, and it decides whether to keep the three results. Every add folds in the carry/link input. Subtraction is done as complement-and-add, so the program sets carry/link before it subtracts. The decimal add treats each byte as two BCD digits and never alters overflow. A group of single-byte opcodes shifts or rotates the accumulator right, either alone or through carry/link.

Top module: `alu8_dec`

## Requirements
- R1: When opcode bits [7:6] are 01 or 11, bits [5:3] choose the operation: 000 load, 010 AND, 011 OR, 100 XOR, 101 decimal add, 110 binary add, 111 complement-add. Bits [2:0] have no effect on the result.
- R2: Load returns the operand. AND, OR and XOR combine the accumulator with the operand bitwise. All four pass carry/link and overflow through unchanged.
- R3: Binary add returns (acc + operand + cy) mod 256. Carry/link becomes the carry out of bit 7. Overflow is set exactly when the signed sum lies outside -128..127.
- R4: Complement-add returns (acc + (255 - operand) + cy) mod 256 and sets carry/link and overflow in the same way as R3. With cy = 1 the result is acc - operand, and carry/link is 1 exactly when acc >= operand as unsigned values.
- R5: Decimal add with valid BCD inputs (each nibble 0..9) returns the two-digit BCD form of (A + B + cy) mod 100, where A and B are the decimal values of the bytes. Carry/link is 1 exactly when A + B + cy >= 100. Overflow is unchanged.
- R6: Opcode 0x1C shifts the accumulator right with 0 entering bit 7. Opcode 0x1D shifts it right with carry/link entering bit 7. Both leave carry/link and overflow unchanged.
- R7: Opcode 0x1E rotates the accumulator right, bit 0 entering bit 7, and leaves both flags unchanged. Opcode 0x1F rotates through carry/link as a 9-bit ring: the result is {cy, acc[7:1]}, carry/link becomes acc[0], and overflow is unchanged.
- R8: Any other opcode, including the [5:3] = 001 slot of the R1 families, returns the accumulator, carry/link and overflow inputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 8 | Instruction byte being executed |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Operand byte (memory data or extension register) |
| cy_i | input | 1 | Current carry/link flag |
| ov_i | input | 1 | Current overflow flag |
| acc_o | output | 8 | Next accumulator value |
| cy_o | output | 1 | Next carry/link flag |
| ov_o | output | 1 | Next overflow flag |

## Verification
The hardest case is a decimal add where the low digit's correction produces a carry, that carry pushes the high digit past nine, and the high digit is corrected in turn. An example is 99 + 00 + 1, which must give 00 with carry set. Only a few operand pairs reach this, and a stray carry-in makes it worse. The bench therefore sweeps every valid BCD pair with both carry-in values, so each double-correction path is visited. The binary and complement adds are swept over all operand pairs and both carries, which covers every signed overflow boundary.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW     = 8;
    localparam int NIB    = 4;
    localparam int DIGITS = DW / NIB;

    typedef enum logic [3:0] {
        OP_LOAD,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_DEC,
        OP_BIN,
        OP_CMP,
        OP_SR,
        OP_SRL,
        OP_RR,
        OP_RRL,
        OP_HOLD
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          cy;
        logic          ov;
    } alu_res_t;

    // Map an instruction byte onto an internal operation.
    function automatic alu_op_e decode_op(input logic [7:0] opc);
        alu_op_e op;
        op = OP_HOLD;
        if (opc[7:6] == 2'b01 || opc[7:6] == 2'b11) begin
            case (opc[5:3])
                3'b000:  op = OP_LOAD;
                3'b010:  op = OP_AND;
                3'b011:  op = OP_OR;
                3'b100:  op = OP_XOR;
                3'b101:  op = OP_DEC;
                3'b110:  op = OP_BIN;
                3'b111:  op = OP_CMP;
                default: op = OP_HOLD;
            endcase
        end else if (opc[7:2] == 6'b000111) begin
            case (opc[1:0])
                2'b00:   op = OP_SR;
                2'b01:   op = OP_SRL;
                2'b10:   op = OP_RR;
                default: op = OP_RRL;
            endcase
        end
        return op;
    endfunction

    // One BCD digit with carry in; returns {carry_out, digit}.
    function automatic logic [NIB:0] bcd_digit(input logic [NIB-1:0] a,
                                               input logic [NIB-1:0] b,
                                               input logic           cin);
        logic [NIB:0] raw;
        logic [NIB:0] adj;
        raw = {1'b0, a} + {1'b0, b} + {{NIB{1'b0}}, cin};
        adj = raw + (NIB+1)'(6);
        if (raw > (NIB+1)'(9))
            return {1'b1, adj[NIB-1:0]};
        return {1'b0, raw[NIB-1:0]};
    endfunction

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [7:0] opcode_i,
    output alu_op_e    op_o
);
    always_comb op_o = decode_op(opcode_i);
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic         cy_i,
    output logic [W-1:0] val_o,
    output logic         cy_o
);
    always_comb begin
        val_o = acc_i;
        cy_o  = cy_i;
        unique case (op_i)
            OP_LOAD: val_o = opnd_i;
            OP_AND:  val_o = acc_i & opnd_i;
            OP_OR:   val_o = acc_i | opnd_i;
            OP_XOR:  val_o = acc_i ^ opnd_i;
            OP_SR:   val_o = {1'b0, acc_i[W-1:1]};
            OP_SRL:  val_o = {cy_i, acc_i[W-1:1]};
            OP_RR:   val_o = {acc_i[0], acc_i[W-1:1]};
            OP_RRL: begin
                val_o = {cy_i, acc_i[W-1:1]};
                cy_o  = acc_i[0];
            end
            default: val_o = acc_i;
        endcase
    end
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         invert_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic         cy_i,
    output alu_res_t     res_o
);
    logic [W-1:0] addend;
    logic [W:0]   total;

    always_comb begin
        addend     = invert_i ? ~opnd_i : opnd_i;
        total      = {1'b0, acc_i} + {1'b0, addend} + {{W{1'b0}}, cy_i};
        res_o.val  = total[W-1:0];
        res_o.cy   = total[W];
        res_o.ov   = (acc_i[W-1] == addend[W-1]) && (total[W-1] != acc_i[W-1]);
    end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
    import alu8_pkg::*;
#(
    parameter int ND = DIGITS
) (
    input  logic [ND*NIB-1:0] acc_i,
    input  logic [ND*NIB-1:0] opnd_i,
    input  logic              cy_i,
    output logic [ND*NIB-1:0] val_o,
    output logic              cy_o
);
    logic [ND:0] chain;
    assign chain[0] = cy_i;

    for (genvar g = 0; g < ND; g++) begin : g_digit
        logic [NIB:0] dsum;
        assign dsum = bcd_digit(acc_i[g*NIB +: NIB], opnd_i[g*NIB +: NIB], chain[g]);
        assign val_o[g*NIB +: NIB] = dsum[NIB-1:0];
        assign chain[g+1]          = dsum[NIB];
    end

    assign cy_o = chain[ND];
endmodule

// File: rtl/alu8_dec.sv
module alu8_dec
    import alu8_pkg::*;
(
    input  logic [7:0]    opcode_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opnd_i,
    input  logic          cy_i,
    input  logic          ov_i,
    output logic [DW-1:0] acc_o,
    output logic          cy_o,
    output logic          ov_o
);
    alu_op_e       op;
    alu_res_t      bin_res;
    logic [DW-1:0] bit_val;
    logic          bit_cy;
    logic [DW-1:0] bcd_val;
    logic          bcd_cy;

    alu8_decode u_dec (
        .opcode_i (opcode_i),
        .op_o     (op)
    );

    alu8_bitops #(.W(DW)) u_bit (
        .op_i   (op),
        .acc_i  (acc_i),
        .opnd_i (opnd_i),
        .cy_i   (cy_i),
        .val_o  (bit_val),
        .cy_o   (bit_cy)
    );

    alu8_adder #(.W(DW)) u_add (
        .invert_i (op == OP_CMP),
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .cy_i     (cy_i),
        .res_o    (bin_res)
    );

    alu8_bcd #(.ND(DIGITS)) u_bcd (
        .acc_i  (acc_i),
        .opnd_i (opnd_i),
        .cy_i   (cy_i),
        .val_o  (bcd_val),
        .cy_o   (bcd_cy)
    );

    always_comb begin
        acc_o = bit_val;
        cy_o  = bit_cy;
        ov_o  = ov_i;
        case (op)
            OP_BIN, OP_CMP: begin
                acc_o = bin_res.val;
                cy_o  = bin_res.cy;
                ov_o  = bin_res.ov;
            end
            OP_DEC: begin
                acc_o = bcd_val;
                cy_o  = bcd_cy;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_dec_chk.sv
module alu8_dec_chk (
    input logic [7:0] opcode_i,
    input logic [7:0] acc_i,
    input logic [7:0] opnd_i,
    input logic       cy_i,
    input logic       ov_i,
    input logic [7:0] acc_o,
    input logic       cy_o,
    input logic       ov_o
);
    logic fam;
    logic [2:0] sel;
    always_comb begin
        fam = (opcode_i[7:6] == 2'b01) || (opcode_i[7:6] == 2'b11);
        sel = opcode_i[5:3];

        // R2
        if (fam && (sel == 3'b000 || sel == 3'b010 || sel == 3'b011 || sel == 3'b100))
            logic_flags_chk: assert (cy_o == cy_i && ov_o == ov_i);

        // R2
        if (fam && sel == 3'b000)
            load_val_chk: assert (acc_o == opnd_i);

        // R5
        if (fam && sel == 3'b101)
            dec_ov_chk: assert (ov_o == ov_i);

        // R6
        if (opcode_i == 8'h1C)
            sr_chk: assert (acc_o == {1'b0, acc_i[7:1]} && cy_o == cy_i && ov_o == ov_i);

        // R7
        if (opcode_i == 8'h1F)
            rrl_chk: assert (acc_o == {cy_i, acc_i[7:1]} && cy_o == acc_i[0] && ov_o == ov_i);

        // R8
        if ((fam && sel == 3'b001) || opcode_i == 8'h00 || opcode_i == 8'h80)
            hold_chk: assert (acc_o == acc_i && cy_o == cy_i && ov_o == ov_i);
    end
endmodule

bind alu8_dec alu8_dec_chk u_chk (.*);

// File: tb/sim_alu8_dec.sv
module sim_alu8_dec;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] opcode_i, acc_i, opnd_i, acc_o;
    logic       cy_i, ov_i, cy_o, ov_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    alu8_dec u0 (
        .opcode_i (opcode_i),
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .cy_i     (cy_i),
        .ov_i     (ov_i),
        .acc_o    (acc_o),
        .cy_o     (cy_o),
        .ov_o     (ov_o)
    );

    task automatic drive(input logic [7:0] opc, input logic [7:0] a,
                         input logic [7:0] b, input logic c, input logic v);
        opcode_i = opc; acc_i = a; opnd_i = b; cy_i = c; ov_i = v;
        #1;
    endtask

    task automatic expect3(input string tag, input logic [7:0] ea,
                           input logic ec, input logic ev);
        checks++;
        if (acc_o !== ea || cy_o !== ec || ov_o !== ev) begin
            errors++;
            $display("FAIL %s op=%02h a=%02h b=%02h c=%0b v=%0b got acc=%02h cy=%0b ov=%0b exp acc=%02h cy=%0b ov=%0b",
                     tag, opcode_i, acc_i, opnd_i, cy_i, ov_i, acc_o, cy_o, ov_o, ea, ec, ev);
        end
    endtask

    function automatic logic [7:0] opfam(input int sel, input int k);
        return 8'(((k % 2) ? 8'h40 : 8'hC0) | (sel << 3) | ((k * 3) % 8));
    endfunction

    initial begin
        logic [7:0] ea;
        logic ec, ev;
        int s, sa, sb, ss, da, db;

        // Reset-like idle state: all zero inputs under a hold opcode (R8)
        drive(8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
        expect3("R8 idle", 8'h00, 1'b0, 1'b0);

        // R1 R2: load and logic ops, low opcode bits varied
        for (int sel = 0; sel < 5; sel++) begin
            if (sel == 1) continue;
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b += 5) begin
                    ec = 1'((a + b) % 2);
                    ev = 1'((a / 3) % 2);
                    drive(opfam(sel, a + b), 8'(a), 8'(b), ec, ev);
                    case (sel)
                        0: ea = 8'(b);
                        2: ea = 8'(a & b);
                        3: ea = 8'(a | b);
                        default: ea = 8'(a ^ b);
                    endcase
                    expect3("R1 R2 logic", ea, ec, ev);
                end
            end
        end

        // R3 R4: exhaustive binary and complement add
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    for (int c = 0; c < 2; c++) begin
                        int bb;
                        bb = m ? 255 - b : b;
                        s  = a + bb + c;
                        sa = (a > 127) ? a - 256 : a;
                        sb = (bb > 127) ? bb - 256 : bb;
                        ss = sa + sb + c;
                        drive(opfam(m ? 7 : 6, a + c), 8'(a), 8'(b), 1'(c), 1'(b % 2));
                        expect3(m ? "R4 cmp add" : "R3 bin add", 8'(s % 256),
                                1'(s > 255), 1'(ss > 127 || ss < -128));
                        if (m == 1 && c == 1) begin
                            checks++;
                            if (cy_o !== 1'(a >= b)) begin
                                errors++;
                                $display("FAIL R4 borrow a=%02h b=%02h got cy=%0b exp cy=%0b",
                                         a, b, cy_o, a >= b);
                            end
                        end
                    end
                end
            end
        end

        // R5: every valid BCD pair, both carries, both overflow inputs
        for (int a = 0; a < 100; a++) begin
            for (int b = 0; b < 100; b++) begin
                for (int c = 0; c < 2; c++) begin
                    da = ((a / 10) << 4) | (a % 10);
                    db = ((b / 10) << 4) | (b % 10);
                    s  = a + b + c;
                    ev = 1'((a + b) % 2);
                    drive(opfam(5, a), 8'(da), 8'(db), 1'(c), ev);
                    expect3("R5 dec add", 8'((((s % 100) / 10) << 4) | (s % 10)),
                            1'(s >= 100), ev);
                end
            end
        end

        // R6 R7: shifts and rotates
        for (int a = 0; a < 256; a++) begin
            for (int c = 0; c < 2; c++) begin
                for (int v = 0; v < 2; v++) begin
                    drive(8'h1C, 8'(a), 8'hA5, 1'(c), 1'(v));
                    expect3("R6 sr", 8'(a / 2), 1'(c), 1'(v));
                    drive(8'h1D, 8'(a), 8'h5A, 1'(c), 1'(v));
                    expect3("R6 srl", 8'(a / 2 + c * 128), 1'(c), 1'(v));
                    drive(8'h1E, 8'(a), 8'h3C, 1'(c), 1'(v));
                    expect3("R7 rr", 8'(a / 2 + (a % 2) * 128), 1'(c), 1'(v));
                    drive(8'h1F, 8'(a), 8'hC3, 1'(c), 1'(v));
                    expect3("R7 rrl", 8'(a / 2 + c * 128), 1'(a % 2), 1'(v));
                end
            end
        end

        // R8: unused opcodes hold every input
        for (int o = 0; o < 256; o++) begin
            logic [7:0] opc;
            bit used;
            opc  = 8'(o);
            used = ((opc[7:6] == 2'b01 || opc[7:6] == 2'b11) && opc[5:3] != 3'b001)
                   || (opc[7:2] == 6'b000111);
            if (used) continue;
            for (int k = 0; k < 8; k++) begin
                drive(opc, 8'(k * 37 + 5), 8'(k * 91 + 3), 1'(k % 2), 1'((k / 2) % 2));
                expect3("R8 hold", 8'(k * 37 + 5), 1'(k % 2), 1'((k / 2) % 2));
            end
        end

        // Boundary picks
        drive(8'hE8, 8'h99, 8'h00, 1'b1, 1'b1);
        expect3("R5 99+0+1", 8'h00, 1'b1, 1'b1);
        drive(8'hF0, 8'h7F, 8'h00, 1'b1, 1'b0);
        expect3("R3 7F+0+1", 8'h80, 1'b0, 1'b1);
        drive(8'hF8, 8'h80, 8'h01, 1'b1, 1'b0);
        expect3("R4 80-01", 8'h7F, 1'b1, 1'b1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule